// File: doc/BRIEF.md
# Streaming Fixed-Point Sine Unit

This block turns a stream of phase words into a stream of sine values inside one clock domain. Each phase is an unsigned fraction of a full turn. The sine is produced by shift-and-add vector rotation, so the block needs no multipliers and no lookup memory. A producer offers a phase together with an input-valid strobe. The block answers with a signed result and an output-valid strobe, and only after a fixed, known number of cycles.

A build-time switch selects one of two forms. The unrolled form has one rotation stage per iteration, accepts a phase on every clock and returns one result per clock. The folded form reuses a single rotation stage, accepts one phase every 16 cycles and uses far less logic. A second switch adds a register on the result, which costs one more cycle of latency. A downstream ready input stalls the block, and a consumer that can always take data may tie it high.

Top module: `sine_stream`

## Requirements
- R1: The phase is unsigned, and 2^16 codes span one turn: code p stands for the angle 2·π·p/65536. The result is signed 16-bit Q1.14 (16384 = +1.0) and lies within 4 LSB of round(16384·sin(angle)).
- R2: A valid result never exceeds +16384 or falls below −16384.
- R3: In the unrolled form, with outReady high, a phase is accepted on every consecutive cycle and the results leave in acceptance order, one per cycle.
- R4: In the unrolled form without the result register, a phase accepted in cycle c produces outValid in cycle c+16.
- R5: With the result register enabled, the same phase produces outValid in cycle c+17.
- R6: outValid is raised exactly once for each accepted phase, and never for a cycle without one. An idle input gives an idle output.
- R7: While outValid is high and outReady is low, outValid and sineOut stay unchanged. No sample is lost or repeated when the stall ends.
- R8: In the folded form, inReady drops after an acceptance and rises again only when the result is done. With outReady high, acceptances are exactly 16 cycles apart and the latency is 16 cycles.
- R9: A synchronous reset clears every valid flag. outValid is low after reset, and samples that were in flight are discarded.
- R10: In the unrolled form, inReady is high whenever outReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Phase word present |
| inReady | output | 1 | Block can take a phase this cycle |
| phase | input | PHASE_W | Unsigned phase, a full turn spans 2^PHASE_W codes |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Consumer takes the result this cycle |
| sineOut | output | OUT_W | Signed Q1.14 sine |

## Verification
Phases at the quadrant edges (0, π/2, π, 3π/2, the last code before a full turn) test the quadrant folding and the clamp at ±1. A spread of other phases tests the rotation arithmetic. An unbroken stream separates a true one-per-cycle pipeline from one that drops or reorders samples. Gapped input shows whether bubbles travel through the pipeline without making false valids. Periodic back-pressure, alone and combined with gaps, shows whether a stalled result is held without loss or duplication. A single lone sample measures the latency of each variant exactly. A reset asserted while samples are in flight shows that every valid flag is cleared.

// File: rtl/sine_pkg.sv
package sine_pkg;
  // rotation datapath geometry
  localparam int CW       = 20;  // x/y width
  localparam int CFRAC    = 17;  // x/y fraction bits (1.0 = 2^17)
  localparam int ZW       = 22;  // residual angle width
  localparam int ZQUART   = 18;  // log2 of a quarter turn in angle units
  localparam int MAX_ITER = 20;
  localparam int IDX_W    = 5;
  localparam logic signed [CW-1:0] GAIN_INV = 20'sd79594; // 0.60725 * 2^17

  typedef struct packed {
    logic signed [CW-1:0] x;
    logic signed [CW-1:0] y;
    logic signed [ZW-1:0] z;
    logic [1:0]           quad;
  } cordic_t;

  typedef struct packed {
    logic             load;     // take a new seed
    logic             step;     // advance rotation state
    logic             capture;  // load result register
    logic [IDX_W-1:0] idx;      // iteration number (folded form)
  } ctrl_t;

  // arctan(2^-i) with a full turn equal to 2^20 units
  function automatic logic signed [ZW-1:0] atanStep(input int unsigned i);
    case (i)
      0:  return 22'sd131072;
      1:  return 22'sd77376;
      2:  return 22'sd40884;
      3:  return 22'sd20753;
      4:  return 22'sd10417;
      5:  return 22'sd5213;
      6:  return 22'sd2607;
      7:  return 22'sd1304;
      8:  return 22'sd652;
      9:  return 22'sd326;
      10: return 22'sd163;
      11: return 22'sd81;
      12: return 22'sd41;
      13: return 22'sd20;
      14: return 22'sd10;
      15: return 22'sd5;
      16: return 22'sd3;
      17: return 22'sd1;
      18: return 22'sd1;
      default: return '0;
    endcase
  endfunction

  function automatic cordic_t microRotate(input cordic_t s, input int unsigned i);
    cordic_t r;
    r = s;
    if (!s.z[ZW-1]) begin
      r.x = s.x - (s.y >>> i);
      r.y = s.y + (s.x >>> i);
      r.z = s.z - atanStep(i);
    end else begin
      r.x = s.x + (s.y >>> i);
      r.y = s.y - (s.x >>> i);
      r.z = s.z + atanStep(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/sine_ctrl.sv
module sine_ctrl
  import sine_pkg::*;
#(
  parameter int ITER      = 16,
  parameter bit PIPELINED = 1'b1,
  parameter bit OUT_REG   = 1'b0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  inValid,
  output logic  inReady,
  input  logic  outReady,
  output logic  outValid,
  output ctrl_t ctrl
);
  logic coreValid;
  logic downFree;
  logic accept;

  // optional result stage
  if (OUT_REG) begin : g_oreg
    logic outVld;
    always_ff @(posedge clk) begin
      if (rst)           outVld <= 1'b0;
      else if (downFree) outVld <= coreValid;
    end
    assign downFree = outReady | ~outVld;
    assign outValid = outVld;
  end else begin : g_nooreg
    assign downFree = outReady;
    assign outValid = coreValid;
  end

  if (PIPELINED) begin : g_pipe
    logic [ITER-1:0] vld;
    logic            adv;
    assign adv       = downFree | ~coreValid;
    assign inReady   = adv;
    assign accept    = inValid & adv;
    assign coreValid = vld[ITER-1];
    always_ff @(posedge clk) begin
      if (rst)      vld <= '0;
      else if (adv) vld <= {vld[ITER-2:0], accept};
    end
    assign ctrl.load    = accept;
    assign ctrl.step    = adv;
    assign ctrl.capture = downFree;
    assign ctrl.idx     = '0;
  end else begin : g_iter
    logic             busy;
    logic             done;
    logic [IDX_W-1:0] cnt;
    assign coreValid = done;
    assign inReady   = ~busy & (~done | downFree);
    assign accept    = inValid & inReady;
    always_ff @(posedge clk) begin
      if (rst) begin
        busy <= 1'b0;
        done <= 1'b0;
        cnt  <= '0;
      end else if (accept) begin
        busy <= 1'b1;
        done <= 1'b0;
        cnt  <= IDX_W'(1);
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == IDX_W'(ITER-1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (done && downFree) begin
        done <= 1'b0;
      end
    end
    assign ctrl.load    = accept;
    assign ctrl.step    = busy;
    assign ctrl.capture = downFree;
    assign ctrl.idx     = cnt;
  end
endmodule

// File: rtl/sine_datapath.sv
module sine_datapath
  import sine_pkg::*;
#(
  parameter int PHASE_W   = 16,
  parameter int OUT_W     = 16,
  parameter int ITER      = 16,
  parameter bit PIPELINED = 1'b1,
  parameter bit OUT_REG   = 1'b0
) (
  input  logic                      clk,
  input  ctrl_t                     ctrl,
  input  logic        [PHASE_W-1:0] phase,
  output logic signed [OUT_W-1:0]   sineOut
);
  localparam int RES_W = PHASE_W - 2;
  localparam int DROP  = CFRAC - (OUT_W - 2);
  localparam logic signed [CW-1:0] HALF_LSB = CW'(1 << (DROP - 1));
  localparam logic signed [CW-1:0] UNITY    = CW'(1 << (OUT_W - 2));

  cordic_t seedVal;
  cordic_t fin;

  // quadrant split: rotate by the residual inside the quadrant
  always_comb begin
    seedVal.x    = GAIN_INV;
    seedVal.y    = '0;
    seedVal.z    = ZW'(phase[RES_W-1:0]) << (ZQUART - RES_W);
    seedVal.quad = phase[PHASE_W-1 -: 2];
  end

  if (PIPELINED) begin : g_unrolled
    for (genvar k = 0; k < ITER; k++) begin : g_stage
      cordic_t q;
      if (k == 0) begin : g_first
        always_ff @(posedge clk)
          if (ctrl.load) q <= microRotate(seedVal, k);
      end else begin : g_next
        always_ff @(posedge clk)
          if (ctrl.step) q <= microRotate(g_stage[k-1].q, k);
      end
    end
    assign fin = g_stage[ITER-1].q;
    logic unusedIdx;
    assign unusedIdx = ^ctrl.idx;
  end else begin : g_folded
    cordic_t acc;
    always_ff @(posedge clk) begin
      if (ctrl.load)      acc <= microRotate(seedVal, 0);
      else if (ctrl.step) acc <= microRotate(acc, ctrl.idx);
    end
    assign fin = acc;
  end

  // quadrant restore, rounding and clamp
  logic signed [CW-1:0]    picked;
  logic signed [CW-1:0]    rounded;
  logic signed [CW-1:0]    clamped;
  logic signed [OUT_W-1:0] resNext;
  logic                    unusedAngle;
  assign unusedAngle = ^fin.z;

  always_comb begin
    case (fin.quad)
      2'd0:    picked = fin.y;
      2'd1:    picked = fin.x;
      2'd2:    picked = -fin.y;
      default: picked = -fin.x;
    endcase
    rounded = (picked + HALF_LSB) >>> DROP;
    if (rounded > UNITY)       clamped = UNITY;
    else if (rounded < -UNITY) clamped = -UNITY;
    else                       clamped = rounded;
    resNext = clamped[OUT_W-1:0];
  end

  if (OUT_REG) begin : g_oreg
    always_ff @(posedge clk)
      if (ctrl.capture) sineOut <= resNext;
  end else begin : g_nooreg
    assign sineOut = resNext;
    logic unusedCap;
    assign unusedCap = ctrl.capture;
  end
endmodule

// File: rtl/sine_stream.sv
module sine_stream
  import sine_pkg::*;
#(
  parameter int PHASE_W   = 16,
  parameter int OUT_W     = 16,
  parameter int ITER      = 16,
  parameter bit PIPELINED = 1'b1,
  parameter bit OUT_REG   = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      inValid,
  output logic                      inReady,
  input  logic        [PHASE_W-1:0] phase,
  output logic                      outValid,
  input  logic                      outReady,
  output logic signed [OUT_W-1:0]   sineOut
);
  ctrl_t ctrl;

  sine_ctrl #(
    .ITER(ITER), .PIPELINED(PIPELINED), .OUT_REG(OUT_REG)
  ) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .outReady(outReady), .outValid(outValid), .ctrl(ctrl)
  );

  sine_datapath #(
    .PHASE_W(PHASE_W), .OUT_W(OUT_W), .ITER(ITER),
    .PIPELINED(PIPELINED), .OUT_REG(OUT_REG)
  ) u_dp (
    .clk(clk), .ctrl(ctrl), .phase(phase), .sineOut(sineOut)
  );
endmodule

// File: rtl/sine_stream_chk.sv
module sine_stream_chk #(
  parameter int PHASE_W   = 16,
  parameter int OUT_W     = 16,
  parameter int ITER      = 16,
  parameter bit PIPELINED = 1'b1,
  parameter bit OUT_REG   = 1'b0
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    inValid,
  input logic                    inReady,
  input logic [PHASE_W-1:0]      phase,
  input logic                    outValid,
  input logic                    outReady,
  input logic signed [OUT_W-1:0] sineOut
);
  localparam logic signed [OUT_W-1:0] UNITY = OUT_W'(1 << (OUT_W - 2));
  localparam int CAP = ITER + (OUT_REG ? 1 : 0);

  logic [7:0] inFlight;
  logic       unusedPhase;
  assign unusedPhase = ^phase;

  always_ff @(posedge clk) begin
    if (rst) inFlight <= '0;
    else inFlight <= inFlight + 8'(inValid && inReady) - 8'(outValid && outReady);
  end

  p_bounded_r2: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (sineOut <= UNITY && sineOut >= -UNITY));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(sineOut)));

  p_clear_r9: assert property (@(posedge clk)
    rst |=> !outValid);

  p_credit_r6: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (inFlight != 8'd0));

  p_capacity_r6: assert property (@(posedge clk) disable iff (rst)
    inFlight <= 8'(CAP));

  if (PIPELINED) begin : g_pipe_chk
    p_ready_r10: assert property (@(posedge clk) disable iff (rst)
      outReady |-> inReady);
  end else begin : g_iter_chk
    p_busy_r8: assert property (@(posedge clk) disable iff (rst)
      (inValid && inReady) |=> !inReady);
  end
endmodule

bind sine_stream sine_stream_chk #(
  .PHASE_W(PHASE_W), .OUT_W(OUT_W), .ITER(ITER),
  .PIPELINED(PIPELINED), .OUT_REG(OUT_REG)
) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
  .phase(phase), .outValid(outValid), .outReady(outReady), .sineOut(sineOut)
);

// File: tb/tb_sine_stream.sv
`timescale 1ns/1ps
module tb_sine_stream;
  localparam int PW = 16;
  localparam int OW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic outReady = 1'b1;
  logic [PW-1:0] phase = '0;
  logic rdyP, rdyR, rdyI, vP, vR, vI;
  logic signed [OW-1:0] sP, sR, sI;
  int nRun = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  sine_stream #(.PIPELINED(1'b1), .OUT_REG(1'b0)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(rdyP), .phase(phase),
    .outValid(vP), .outReady(outReady), .sineOut(sP));
  sine_stream #(.PIPELINED(1'b1), .OUT_REG(1'b1)) dutReg (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(rdyR), .phase(phase),
    .outValid(vR), .outReady(outReady), .sineOut(sR));
  sine_stream #(.PIPELINED(1'b0), .OUT_REG(1'b0)) dutIter (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(rdyI), .phase(phase),
    .outValid(vI), .outReady(outReady), .sineOut(sI));

  function automatic logic getV(int s);
    return (s == 0) ? vP : (s == 1) ? vR : vI;
  endfunction
  function automatic logic getR(int s);
    return (s == 0) ? rdyP : (s == 1) ? rdyR : rdyI;
  endfunction
  function automatic int getS(int s);
    return (s == 0) ? int'(sP) : (s == 1) ? int'(sR) : int'(sI);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int expSin(int p);
    real a;
    a = 2.0 * 3.14159265358979 * real'(p) / 65536.0;
    return int'($sin(a) * 16384.0);
  endfunction

  function automatic logic [PW-1:0] phaseAt(int k);
    case (k)
      0: return 16'd0;
      1: return 16'd16384;
      2: return 16'd32768;
      3: return 16'd49152;
      4: return 16'd65535;
      5: return 16'd8192;
      6: return 16'd24576;
      7: return 16'd40960;
      default: return PW'(k * 2719 + 123);
    endcase
  endfunction

  task automatic doReset();
    rst = 1'b1; inValid = 1'b0; outReady = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // reset state of all three variants (R9)
  task automatic testReset();
    doReset();
    check(!vP && !vR && !vI, "R9", "outValid after reset", {vP, vR, vI}, 0);
    check(rdyP && rdyR && rdyI, "R9", "inReady after reset", {rdyP, rdyR, rdyI}, 7);
  endtask

  // lone sample: count cycles to outValid (R4, R5, R8)
  task automatic testLatency(int s, int expLat, string req);
    int lat = -1;
    int d;
    doReset();
    inValid = 1'b1; phase = 16'd8192;
    @(negedge clk);
    inValid = 1'b0;
    for (int c = 1; c <= 40 && lat < 0; c++) begin
      if (getV(s)) lat = c;
      else @(negedge clk);
    end
    check(lat == expLat, req, "latency", lat, expLat);
    d = getS(s) - expSin(8192);
    check(d <= 4 && d >= -4, "R1", "lone sample value", getS(s), expSin(8192));
  endtask

  // stream with optional gaps and back-pressure
  task automatic runStream(int s, int n, int gapMod, int stallMod,
                           int spacing, string spReq);
    int sent = 0, got = 0, cyc = 0, lastAcc = -1;
    int expQ[$];
    bit heldPend = 1'b0, rdyAlways = 1'b1, idleOk = 1'b1;
    int heldVal = 0;
    doReset();
    while (got < n && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (heldPend)
        check(getV(s) && getS(s) == heldVal, "R7", "stalled output held", getS(s), heldVal);
      outReady = (stallMod == 0) ? 1'b1 : ((cyc % stallMod) != 0);
      if (sent < n && (gapMod == 0 || (cyc % gapMod) != 0)) begin
        inValid = 1'b1; phase = phaseAt(sent);
      end else inValid = 1'b0;
      #1;
      if (!getR(s)) rdyAlways = 1'b0;
      heldPend = getV(s) && !outReady;
      heldVal  = getS(s);
      if (getV(s) && outReady) begin
        if (expQ.size() == 0) check(1'b0, "R6", "spurious output", getS(s), 0);
        else begin
          int e, d;
          e = expQ.pop_front();
          d = getS(s) - e;
          check(d <= 4 && d >= -4, "R1", "sine value", getS(s), e);
          check(getS(s) <= 16384 && getS(s) >= -16384, "R2", "magnitude", getS(s), 16384);
        end
        got++;
      end
      if (inValid && getR(s)) begin
        expQ.push_back(expSin(int'(phase)));
        if (spacing > 0 && lastAcc >= 0)
          check(cyc - lastAcc == spacing, spReq, "acceptance spacing", cyc - lastAcc, spacing);
        lastAcc = cyc;
        sent++;
      end
    end
    check(got == n, "R6", "result count", got, n);
    if (s != 2 && stallMod == 0)
      check(rdyAlways, "R10", "inReady with outReady high", 0, 1);
    inValid = 1'b0; outReady = 1'b1;
    repeat (24) begin
      @(negedge clk);
      if (getV(s)) idleOk = 1'b0;
    end
    check(idleOk, "R6", "idle input gives idle output", 0, 1);
  endtask

  // reset while samples are in flight (R9)
  task automatic testMidReset();
    bit ok = 1'b1;
    doReset();
    inValid = 1'b1;
    for (int i = 0; i < 5; i++) begin
      phase = phaseAt(i);
      @(negedge clk);
    end
    rst = 1'b1; inValid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    repeat (24) begin
      @(negedge clk);
      if (vP || vR || vI) ok = 1'b0;
    end
    check(ok, "R9", "in-flight samples discarded", 0, 1);
  endtask

  initial begin
    #400000;
    nRun++; nFail++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    testReset();
    testLatency(0, 16, "R4");
    testLatency(1, 17, "R5");
    testLatency(2, 16, "R8");
    runStream(0, 40, 0, 0, 1, "R3");   // back-to-back, R3
    runStream(0, 30, 4, 0, 0, "R6");   // gaps, R6
    runStream(0, 30, 0, 3, 0, "R7");   // back-pressure, R7
    runStream(1, 30, 5, 2, 0, "R7");   // registered output, gaps and stalls
    runStream(1, 20, 0, 0, 1, "R3");
    runStream(2, 6, 0, 0, 16, "R8");   // folded form spacing, R8
    runStream(2, 4, 3, 4, 0, "R7");
    testMidReset();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule